// File: doc/BRIEF.md
# Bit-Manipulating ALU

A purely combinational arithmetic and logic unit for a 16-bit datapath. It takes two operand words, `a` and `b`, plus a 4-bit function select. It returns one result word in the same cycle. The sixteen functions cover the following:

- a pass-through of `b`
- the three bitwise logic operations
- wrapping add, subtract and multiply
- a byte merge
- signed compare-and-set
- fixed one-position shifts
- four single-bit operations whose bit position comes from the low nibble of `b`

The unit sits between a register file read port and a write-back path. It produces no flags and no carry. Every function delivers exactly the low 16 bits of its mathematical result.

Top module: `bitalu`

## Requirements
- R1: Select 0000 gives r = b. Select 0001 gives a AND b. Select 0010 gives a OR b. Select 0011 gives a XOR b.
- R2: Select 0100 gives (a + b) mod 2^16, and select 0101 gives (a − b) mod 2^16. Overflow has no other effect.
- R3: Select 0110 gives the low 16 bits of the unsigned product a × b.
- R4: Select 0111 gives r[15:8] = b[7:0] and r[7:0] = a[7:0].
- R5: Select 1000 gives 1 when a < b and 0 otherwise. Select 1001 gives 1 when a ≤ b and 0 otherwise. Both compares treat the operands as signed two's complement, and r[15:1] is always 0 for these selects.
- R6: Select 1010 gives a shifted right by one position with a zero entering bit 15. Select 1011 gives a shifted left by one position with a zero entering bit 0. For both selects the value of b has no effect on r.
- R7: Let k = b[3:0]. Select 1100 gives a with bit k forced to 1, and select 1101 gives a with bit k forced to 0.
- R8: Let k = b[3:0]. Select 1110 gives a AND (1 << k), and select 1111 gives a word with only bit k set.
- R9: For selects 1100 to 1111, bits b[15:4] have no effect on r.
- R10: r depends only on the present a, b and select. It holds no state and settles in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand; its low nibble is the bit index for selects 1100 to 1111 |
| fn | input | 4 | Function select |
| r | output | 16 | Result word |

## Verification
The hardest cases to reach are the signed compare boundaries, where 0x7FFF and 0x8000 sit next to each other in unsigned order but at opposite ends in signed order. Equal operands also separate 1000 from 1001. Every select is therefore driven with all pairs drawn from a boundary set (0, 1, 0x7FFF, 0x8000, 0xFFFF), so each such pair occurs explicitly. A second case is hard to hit with random stimulus alone: showing that upper bits of b cannot leak into the bit-index functions or the shifts. Directed vectors keep the low nibble or all of a fixed and flip everything else in b, then compare the results against the model.

// File: rtl/bitalu.sv
module bitalu #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       fn,
  output logic [WIDTH-1:0] r
);

  localparam int HALF = WIDTH / 2;
  localparam int IDXW = $clog2(WIDTH);

  localparam logic [3:0] F_PASS = 4'h0, F_AND = 4'h1, F_OR  = 4'h2, F_XOR = 4'h3;
  localparam logic [3:0] F_ADD  = 4'h4, F_SUB = 4'h5, F_MUL = 4'h6, F_MRG = 4'h7;
  localparam logic [3:0] F_LT   = 4'h8, F_LE  = 4'h9, F_SR  = 4'hA, F_SL  = 4'hB;
  localparam logic [3:0] F_SET  = 4'hC, F_CLR = 4'hD, F_TST = 4'hE, F_GEN = 4'hF;

  logic [IDXW-1:0]  idx;
  logic [WIDTH-1:0] pick;
  logic [WIDTH-1:0] prod;
  logic             lt, eq;

  assign idx  = b[IDXW-1:0];
  assign pick = {{(WIDTH-1){1'b0}}, 1'b1} << idx;
  assign prod = a * b;
  assign lt   = $signed(a) < $signed(b);
  assign eq   = a == b;

  always_comb begin
    case (fn)
      F_PASS:  r = b;
      F_AND:   r = a & b;
      F_OR:    r = a | b;
      F_XOR:   r = a ^ b;
      F_ADD:   r = a + b;
      F_SUB:   r = a - b;
      F_MUL:   r = prod;
      F_MRG:   r = {b[HALF-1:0], a[HALF-1:0]};
      F_LT:    r = {{(WIDTH-1){1'b0}}, lt};
      F_LE:    r = {{(WIDTH-1){1'b0}}, lt | eq};
      F_SR:    r = {1'b0, a[WIDTH-1:1]};
      F_SL:    r = {a[WIDTH-2:0], 1'b0};
      F_SET:   r = a | pick;
      F_CLR:   r = a & ~pick;
      F_TST:   r = a & pick;
      default: r = pick;
    endcase
  end

  always_comb begin
    if (fn == F_LT || fn == F_LE)
      assert_cmp_boolean_R5: assert (r[WIDTH-1:1] == '0) else $error("compare result not 0/1");
    if (fn == F_SR)
      assert_shr_zero_fill_R6: assert (!r[WIDTH-1]) else $error("right shift filled a one");
    if (fn == F_SL)
      assert_shl_zero_fill_R6: assert (!r[0]) else $error("left shift filled a one");
    if (fn == F_MRG)
      assert_merge_low_kept_R4: assert (r[HALF-1:0] == a[HALF-1:0]) else $error("merge lost low byte");
    if (fn == F_SET)
      assert_bit_forced_high_R7: assert (r[idx]) else $error("set bit is low");
    if (fn == F_CLR)
      assert_bit_forced_low_R7: assert (!r[idx]) else $error("cleared bit is high");
    if (fn == F_GEN)
      assert_gen_single_R8: assert ($countones(r) == 1) else $error("generated word not one-hot");
    if (fn == F_TST)
      assert_test_at_most_one_R8: assert ($onehot0(r)) else $error("test result has several bits");
  end

endmodule

// File: tb/tb_bitalu.sv
`timescale 1ns/1ps
module tb_bitalu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0, b = '0;
  logic [3:0]  fn = '0;
  logic [15:0] r;
  int          total = 0, fails = 0;

  always #2.5 clk = ~clk;

  bitalu dut (.a(a), .b(b), .fn(fn), .r(r));

  function automatic logic [15:0] model(input logic [15:0] x, y, input logic [3:0] f);
    longint ux = x, uy = y, res;
    int sx = $signed(x), sy = $signed(y);
    int k = y & 15;
    case (f)
      4'd0:  res = uy;
      4'd1:  res = ux & uy;
      4'd2:  res = ux | uy;
      4'd3:  res = ux ^ uy;
      4'd4:  res = ux + uy;
      4'd5:  res = ux - uy;
      4'd6:  res = ux * uy;
      4'd7:  res = (uy << 8) | (ux & 255);
      4'd8:  res = (sx < sy) ? 1 : 0;
      4'd9:  res = (sx <= sy) ? 1 : 0;
      4'd10: res = ux / 2;
      4'd11: res = ux * 2;
      4'd12: res = ux | (longint'(1) << k);
      4'd13: res = ux & ~(longint'(1) << k);
      4'd14: res = ux & (longint'(1) << k);
      default: res = longint'(1) << k;
    endcase
    return 16'(res & 64'hFFFF);
  endfunction

  function automatic string tag(input logic [3:0] f);
    case (f)
      4'd0, 4'd1, 4'd2, 4'd3: return "R1";
      4'd4, 4'd5:             return "R2";
      4'd6:                   return "R3";
      4'd7:                   return "R4";
      4'd8, 4'd9:             return "R5";
      4'd10, 4'd11:           return "R6";
      4'd12, 4'd13:           return "R7";
      default:                return "R8";
    endcase
  endfunction

  task automatic apply(input logic [15:0] x, y, input logic [3:0] f, input string req);
    @(posedge clk);
    a = x; b = y; fn = f;
    @(negedge clk);
    total++;
    if (r !== model(x, y, f)) begin
      fails++;
      $display("FAIL %s fn=%h a=%h b=%h actual=%h expected=%h", req, f, x, y, r, model(x, y, f));
    end
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] edges [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state: zero operands with pass-through give zero (R1, R10)
    apply(16'h0000, 16'h0000, 4'h0, "R1");
    for (int f = 0; f < 16; f++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply(edges[i], edges[j], 4'(f), tag(4'(f)));
    // R6: b has no effect on the shifts
    for (int f = 10; f < 12; f++) begin
      apply(16'hA5C3, 16'h0000, 4'(f), "R6");
      apply(16'hA5C3, 16'hFFFF, 4'(f), "R6");
      apply(16'hA5C3, 16'h1234, 4'(f), "R6");
    end
    // R9: upper bits of b ignored by bit-index selects
    for (int f = 12; f < 16; f++)
      for (int k = 0; k < 16; k++) begin
        apply(16'h3C96, 16'(k), 4'(f), "R9");
        apply(16'h3C96, 16'hFFF0 | 16'(k), 4'(f), "R9");
        apply(16'h3C96, 16'h5A50 | 16'(k), 4'(f), "R9");
      end
    // R10: random back-to-back changes, result settles in the same cycle
    for (int n = 0; n < 2000; n++) begin
      logic [3:0] f = 4'($urandom);
      apply(16'($urandom), 16'($urandom), f, (n % 2) ? "R10" : tag(f));
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule